// File: doc/BRIEF.md
# Vector word-rotate mask-insert unit

This execution unit handles one 128-bit vector instruction. It decodes a 32-bit instruction word and reads two operands from an external 128-entry vector register file: a source vector and the current contents of the destination register. The source is rotated left by whole 32-bit words, from zero to three positions. The rotated words are then merged into the old destination under a 4-bit lane mask. The merged vector is written back to the destination register.

The unit drives both read indices combinationally from the instruction word. The register file returns the data in the same cycle. One clock after a valid word is presented, the unit registers the result and pulses a write enable. A word that does not match the opcode pattern raises a one-cycle illegal flag and causes no write. The instruction never updates any condition, exception or status register.

Top module: `vec_rot_ins_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rf_wr_en` and `illegal_op` are 0.
- R2: The word is bit-numbered with bit 0 as the most significant bit, which is `instr_word[31]`. A word is accepted only when `instr_word & 32'hFC000730 == 32'h18000710`. This fixes the primary opcode 6 in bits 0-5, the extended opcode 111 in bits 21-23 and the value 01 in bits 26-27.
- R3: `rf_rd_src_idx` equals `{instr_word[1:0], instr_word[15:11]}` and `rf_rd_dst_idx` equals `{instr_word[3:2], instr_word[25:21]}`. Both are driven combinationally.
- R4: Lane 0 is data bits 127:96 and lane 3 is bits 31:0. With rotation count z = `instr_word[7:6]`, rotated lane i holds source lane (z+i) mod 4.
- R5: The mask is `instr_word[19:16]`. Mask bit (3-i) selects lane i of the result. A 1 takes the rotated source word and a 0 keeps the old destination word.
- R6: A mask of 0000 still writes, and the written value is the old destination unchanged. A mask of 1111 writes the fully rotated source.
- R7: An accepted word produces exactly one `rf_wr_en` pulse, in the clock after it is presented. That pulse carries `rf_wr_idx` equal to the destination index. With `instr_valid` low, no write occurs.
- R8: A valid word that fails the R2 match pulses `illegal_op` for one cycle in the next clock and does not assert `rf_wr_en`.
- R9: Immediate bit 4 (`instr_word[20]`) has no effect on the written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is presented this cycle |
| instr_word | input | 32 | Instruction word |
| rf_rd_src_idx | output | 7 | Source register read index |
| rf_rd_src_data | input | 128 | Source register read data |
| rf_rd_dst_idx | output | 7 | Destination register read index |
| rf_rd_dst_data | input | 128 | Old destination register read data |
| rf_wr_en | output | 1 | Register file write enable pulse |
| rf_wr_idx | output | 7 | Register file write index |
| rf_wr_data | output | 128 | Register file write data |
| illegal_op | output | 1 | Unmatched opcode pulse |

## Verification
The bench builds the unit with the default lane width of 32 bits. At that width every lane carries a distinct pattern, so a wrong rotation amount or a reversed mask bit shows up as a misplaced word. The table walks all four rotation counts and a spread of masks, including 0000 and 1111. It also drives register indices at 0, 127 and mixed high/low splits. Directed cases corrupt each fixed opcode field in turn and present a legal word with the valid input low.

// File: rtl/vec_rot_ins_unit.sv
module vec_rot_ins_unit #(
  parameter int LANE_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  instr_valid,
  input  logic [31:0]           instr_word,
  output logic [6:0]            rf_rd_src_idx,
  input  logic [4*LANE_W-1:0]   rf_rd_src_data,
  output logic [6:0]            rf_rd_dst_idx,
  input  logic [4*LANE_W-1:0]   rf_rd_dst_data,
  output logic                  rf_wr_en,
  output logic [6:0]            rf_wr_idx,
  output logic [4*LANE_W-1:0]   rf_wr_data,
  output logic                  illegal_op
);
  localparam int LANES = 4;
  localparam int VEC_W = LANES * LANE_W;
  localparam logic [31:0] MATCH_MASK = 32'hFC00_0730;
  localparam logic [31:0] MATCH_VAL  = 32'h1800_0710;

  logic [1:0]        rot_cnt;
  logic [3:0]        lane_mask;
  logic              is_match;
  logic [LANE_W-1:0] src_lane [LANES];
  logic [VEC_W-1:0]  merged;
  logic              unused_imm_hi;

  assign rot_cnt       = instr_word[7:6];
  assign lane_mask     = instr_word[19:16];
  assign unused_imm_hi = instr_word[20];
  assign is_match      = (instr_word & MATCH_MASK) == MATCH_VAL;
  assign rf_rd_src_idx = {instr_word[1:0], instr_word[15:11]};
  assign rf_rd_dst_idx = {instr_word[3:2], instr_word[25:21]};

  for (genvar j = 0; j < LANES; j++) begin : g_src
    assign src_lane[j] = rf_rd_src_data[VEC_W-1-j*LANE_W -: LANE_W];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [1:0] sel;
    assign sel = rot_cnt + 2'(i);
    assign merged[VEC_W-1-i*LANE_W -: LANE_W] =
      lane_mask[LANES-1-i] ? src_lane[sel] : rf_rd_dst_data[VEC_W-1-i*LANE_W -: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf_wr_en   <= 1'b0;
      illegal_op <= 1'b0;
      rf_wr_idx  <= '0;
      rf_wr_data <= '0;
    end else begin
      rf_wr_en   <= instr_valid && is_match;
      illegal_op <= instr_valid && !is_match;
      if (instr_valid && is_match) begin
        rf_wr_idx  <= rf_rd_dst_idx;
        rf_wr_data <= merged;
      end
    end
  end
endmodule

// File: rtl/vec_rot_ins_chk.sv
module vec_rot_ins_chk #(
  parameter int LANE_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                instr_valid,
  input logic [31:0]         instr_word,
  input logic [6:0]          rf_rd_src_idx,
  input logic [4*LANE_W-1:0] rf_rd_src_data,
  input logic [6:0]          rf_rd_dst_idx,
  input logic [4*LANE_W-1:0] rf_rd_dst_data,
  input logic                rf_wr_en,
  input logic [6:0]          rf_wr_idx,
  input logic [4*LANE_W-1:0] rf_wr_data,
  input logic                illegal_op
);
  logic unused_src_idx;
  assign unused_src_idx = ^rf_rd_src_idx;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!rf_wr_en && !illegal_op));

  assert_idle_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> (!rf_wr_en && !illegal_op));

  assert_write_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |=> (!rf_wr_en || rf_wr_idx == $past(rf_rd_dst_idx)));

  assert_illegal_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_wr_en, illegal_op}));

  assert_empty_mask_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_word[19:16] == 4'h0) |=> (!rf_wr_en || rf_wr_data == $past(rf_rd_dst_data)));

  assert_full_mask_no_rot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_word[19:16] == 4'hF && instr_word[7:6] == 2'd0)
      |=> (!rf_wr_en || rf_wr_data == $past(rf_rd_src_data)));
endmodule

bind vec_rot_ins_unit vec_rot_ins_chk #(.LANE_W(LANE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
  .rf_rd_src_idx(rf_rd_src_idx), .rf_rd_src_data(rf_rd_src_data),
  .rf_rd_dst_idx(rf_rd_dst_idx), .rf_rd_dst_data(rf_rd_dst_data),
  .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
  .illegal_op(illegal_op)
);

// File: tb/vec_rot_ins_unit_tb_top.sv
module vec_rot_ins_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;
  localparam logic [127:0] SRC = 128'h11111111_22222222_33333333_44444444;
  localparam logic [127:0] DST = 128'h55555555_66666666_77777777_88888888;

  localparam logic [1:0]   T_Z   [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1, 2'd3, 2'd2, 2'd1};
  localparam logic [4:0]   T_IMM [NV] = '{5'h0F, 5'h0F, 5'h0F, 5'h0F, 5'h00, 5'h08, 5'h01, 5'h06, 5'h15};
  localparam logic [6:0]   T_VD  [NV] = '{7'd5, 7'd127, 7'd0, 7'd64, 7'd33, 7'd96, 7'd31, 7'd100, 7'd7};
  localparam logic [6:0]   T_VB  [NV] = '{7'd9, 7'd0, 7'd127, 7'd31, 7'd66, 7'd3, 7'd97, 7'd45, 7'd120};
  localparam logic [127:0] T_EXP [NV] = '{
    128'h11111111_22222222_33333333_44444444,
    128'h22222222_33333333_44444444_11111111,
    128'h33333333_44444444_11111111_22222222,
    128'h44444444_11111111_22222222_33333333,
    128'h55555555_66666666_77777777_88888888,
    128'h22222222_66666666_77777777_88888888,
    128'h55555555_66666666_77777777_33333333,
    128'h55555555_44444444_11111111_88888888,
    128'h55555555_33333333_77777777_11111111};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic [127:0] src_data = '0, dst_data = '0;
  logic [6:0] rd_src_idx, rd_dst_idx, wr_idx;
  logic [127:0] wr_data;
  logic wr_en, illegal;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_rot_ins_unit #(.LANE_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .rf_rd_src_idx(rd_src_idx), .rf_rd_src_data(src_data),
    .rf_rd_dst_idx(rd_dst_idx), .rf_rd_dst_data(dst_data),
    .rf_wr_en(wr_en), .rf_wr_idx(wr_idx), .rf_wr_data(wr_data), .illegal_op(illegal));

  function automatic logic [31:0] mk(logic [1:0] z, logic [4:0] imm, logic [6:0] vd, logic [6:0] vb);
    mk = 32'h1800_0710 | (32'(vd[4:0]) << 21) | (32'(imm) << 16) | (32'(vb[4:0]) << 11)
       | (32'(z) << 6) | (32'(vd[6:5]) << 2) | 32'(vb[6:5]);
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] w, logic v);
    @(negedge clk);
    instr_word = w; instr_valid = v; src_data = SRC; dst_data = DST;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 wr_en in reset", 128'(wr_en), 128'd0);
    chk("R1 illegal in reset", 128'(illegal), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 wr_en after reset", 128'(wr_en), 128'd0);
    chk("R1 illegal after reset", 128'(illegal), 128'd0);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      instr_word = mk(T_Z[k], T_IMM[k], T_VD[k], T_VB[k]);
      instr_valid = 1'b1; src_data = SRC; dst_data = DST;
      #1;
      chk("R3 src idx", 128'(rd_src_idx), 128'(T_VB[k]));
      chk("R3 dst idx", 128'(rd_dst_idx), 128'(T_VD[k]));
      @(negedge clk);
      instr_valid = 1'b0;
      chk("R7 wr_en pulse", 128'(wr_en), 128'd1);
      chk("R2 legal not flagged", 128'(illegal), 128'd0);
      chk("R7 wr_idx", 128'(wr_idx), 128'(T_VD[k]));
      chk(k == 8 ? "R9 imm bit4 ignored" : (k < 5 ? "R4 R6 rotated data" : "R5 masked data"),
          wr_data, T_EXP[k]);
      @(negedge clk);
      chk("R7 single pulse", 128'(wr_en), 128'd0);
    end

    issue(mk(2'd1, 5'h0F, 7'd10, 7'd11), 1'b0);
    chk("R7 no write without valid", 128'(wr_en), 128'd0);
    chk("R7 no flag without valid", 128'(illegal), 128'd0);

    issue(32'h1000_0710, 1'b1);
    chk("R8 bad primary opcode flag", 128'(illegal), 128'd1);
    chk("R8 bad primary opcode no write", 128'(wr_en), 128'd0);
    issue(32'h1800_0610, 1'b1);
    chk("R2 bad extended opcode flag", 128'(illegal), 128'd1);
    chk("R2 bad extended opcode no write", 128'(wr_en), 128'd0);
    issue(32'h1800_0730, 1'b1);
    chk("R2 bad bits 26-27 flag", 128'(illegal), 128'd1);
    @(negedge clk);
    chk("R8 flag is one cycle", 128'(illegal), 128'd0);

    issue(mk(2'd3, 5'h10, 7'd2, 7'd3), 1'b1);
    chk("R6 empty mask writes", 128'(wr_en), 128'd1);
    chk("R6 R9 empty mask with bit4 keeps dst", wr_data, DST);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule